// File: doc/BRIEF.md
# Two-stage watchdog reset controller

This block supervises a processor with a watchdog that escalates in two steps, and produces the board's reset pulses. Once software enables it, the watchdog counts an external millisecond tick. The first expiry warns the processor: it holds a non-maskable interrupt and/or sends a short INIT pulse. If software still does not service the watchdog, a second expiry of the same length resets the board. Besides the watchdog, a front-panel switch and a rear-module reset line can also request a reset. For each of these three sources, software chooses whether the reset is hard or soft.

A hard reset drives the system reset output for a fixed number of cycles and returns the configuration to its defaults. A soft reset only pulses INIT and keeps the configuration. Every reset records its cause in an event register that survives a hard reset, so software can find the cause after restart. Software reaches all registers through two locations: a write with the select bit low loads an index, and a data access then reaches the register at that index. Two board status lines, hot-swap switch and ejector latch, are passed through as interrupts under enable bits.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: A bus write with `bus_dsel_i`=0 loads the index. `bus_rdata_o` always shows the register at the current index. A write with `bus_dsel_i`=1 writes that register. The indices are: 0x01 control (bit 4 enable, bits 2:0 period select, other bits read 0), 0x02 kick (reads 0), 0x03 interrupt enables (bit 0 NMI, bit 1 INIT, bit 2 hot-swap, bit 3 latch), 0x04 reset event, and 0x05 reset attribute. Every other index reads 0 and ignores writes.
- R2: After power-on reset, every register reads 0 and `sys_rst_o`, `init_o` and `nmi_o` are low.
- R3: While the watchdog is enabled, its first stage expires on the 2^(sel+4)-th tick. At that point `nmi_o` rises and stays high if the NMI enable is set, and `init_o` pulses for 4 cycles if the INIT enable is set.
- R4: If no kick arrives, the second stage expires after another 2^(sel+4) ticks and raises a watchdog reset.
- R5: Any data write to the kick index or the control index restarts the first stage and clears `nmi_o`. A kick after the first expiry cancels the pending reset. A disabled watchdog never expires.
- R6: A hard reset drives `sys_rst_o` high for exactly 16 cycles. It returns the index, control, interrupt-enable and attribute registers to 0 and keeps the event register.
- R7: A soft reset drives `init_o` high for exactly 4 cycles and leaves every configuration register unchanged.
- R8: The attribute register sets each source's reset type: bit 0 front panel, bit 1 rear module, bit 2 watchdog. A 0 selects hard and a 1 selects soft.
- R9: Each reset overwrites the event register with a one-hot code that uses the bit positions of R8. Writing 0xFF clears it. Any other write leaves it unchanged.
- R10: The front-panel and rear-module inputs act on their rising edge only, so holding one high does not retrigger. When requests coincide, the front panel wins over the rear module, which wins over the watchdog.
- R11: `swap_irq_o` follows `swap_sw_i` and `latch_irq_o` follows `latch_open_i` while their enable bits are set. Otherwise they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low power-on reset |
| bus_wr_i | input | 1 | register port write strobe |
| bus_dsel_i | input | 1 | 0 selects the index, 1 selects data |
| bus_wdata_i | input | 8 | write data |
| bus_rdata_o | output | 8 | register at the current index |
| tick_i | input | 1 | one-cycle watchdog time base pulse |
| fp_rst_i | input | 1 | front-panel reset request |
| rtm_rst_i | input | 1 | rear-module reset request |
| swap_sw_i | input | 1 | hot-swap switch level |
| latch_open_i | input | 1 | ejector latch open level |
| sys_rst_o | output | 1 | hard system reset |
| init_o | output | 1 | processor INIT (soft reset) |
| nmi_o | output | 1 | non-maskable interrupt |
| swap_irq_o | output | 1 | gated hot-swap interrupt |
| latch_irq_o | output | 1 | gated latch interrupt |

## Verification
The hardest case to reach is a kick that arrives after the first expiry, because the timer must leave its second stage without giving any sign of a reset. The stimulus lets the first stage expire and confirms that `nmi_o` is high. It then kicks and feeds one more full period, so the first stage expires again instead of the hard reset. Only after that does it let both stages run out. Coincident front-panel and rear requests with mixed attributes are raised in the same cycle to check the priority order.

// File: rtl/wdog_rst_pkg.sv
package wdog_rst_pkg;
  localparam int DW = 8;
  localparam int NSRC = 3;
  localparam int SRC_FP = 0;
  localparam int SRC_RTM = 1;
  localparam int SRC_WD = 2;
  localparam int CTL_EN_BIT = 4;
  localparam logic [DW-1:0] IX_CTRL = 8'h01;
  localparam logic [DW-1:0] IX_KICK = 8'h02;
  localparam logic [DW-1:0] IX_IEN  = 8'h03;
  localparam logic [DW-1:0] IX_EVT  = 8'h04;
  localparam logic [DW-1:0] IX_ATTR = 8'h05;
  localparam logic [DW-1:0] EVT_CLR = 8'hFF;
  typedef enum logic [1:0] {WS_IDLE, WS_ARM, WS_LAST} wstage_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_rst_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_i,
  input  logic             bus_dsel_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             hard_clr_i,
  input  logic             evt_we_i,
  input  logic [NSRC-1:0]  evt_code_i,
  output logic             wd_en_o,
  output logic [SEL_W-1:0] wd_sel_o,
  output logic [3:0]       ien_o,
  output logic [NSRC-1:0]  attr_o,
  output logic [NSRC-1:0]  evt_o,
  output logic             restart_o
);
  logic [DW-1:0]    idx_q, idx_d;
  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [3:0]       ien_q, ien_d;
  logic [NSRC-1:0]  attr_q, attr_d;
  logic [NSRC-1:0]  evt_q, evt_d;
  logic             idx_wr, dat_wr;

  assign idx_wr = bus_wr_i & ~bus_dsel_i;
  assign dat_wr = bus_wr_i & bus_dsel_i;

  always_comb begin
    idx_d  = idx_q;
    en_d   = en_q;
    sel_d  = sel_q;
    ien_d  = ien_q;
    attr_d = attr_q;
    evt_d  = evt_q;
    if (idx_wr) idx_d = bus_wdata_i;
    if (dat_wr) begin
      case (idx_q)
        IX_CTRL: begin
          en_d  = bus_wdata_i[CTL_EN_BIT];
          sel_d = bus_wdata_i[SEL_W-1:0];
        end
        IX_IEN:  ien_d  = bus_wdata_i[3:0];
        IX_ATTR: attr_d = bus_wdata_i[NSRC-1:0];
        IX_EVT:  if (bus_wdata_i == EVT_CLR) evt_d = '0;
        default: ;
      endcase
    end
    if (hard_clr_i) begin
      idx_d  = '0;
      en_d   = 1'b0;
      sel_d  = '0;
      ien_d  = '0;
      attr_d = '0;
    end
    if (evt_we_i) evt_d = evt_code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      en_q   <= 1'b0;
      sel_q  <= '0;
      ien_q  <= '0;
      attr_q <= '0;
      evt_q  <= '0;
    end else begin
      idx_q  <= idx_d;
      en_q   <= en_d;
      sel_q  <= sel_d;
      ien_q  <= ien_d;
      attr_q <= attr_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (idx_q)
      IX_CTRL: begin
        bus_rdata_o[CTL_EN_BIT]  = en_q;
        bus_rdata_o[SEL_W-1:0]   = sel_q;
      end
      IX_IEN:  bus_rdata_o[3:0]      = ien_q;
      IX_EVT:  bus_rdata_o[NSRC-1:0] = evt_q;
      IX_ATTR: bus_rdata_o[NSRC-1:0] = attr_q;
      default: ;
    endcase
  end

  assign restart_o = dat_wr & ((idx_q == IX_KICK) | (idx_q == IX_CTRL));
  assign wd_en_o   = en_q;
  assign wd_sel_o  = sel_q;
  assign ien_o     = ien_q;
  assign attr_o    = attr_q;
  assign evt_o     = evt_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_rst_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             clr_i,
  output logic             s1_exp_o,
  output logic             s2_exp_o
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W);

  wstage_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;
  logic             step;

  assign last_cnt = (CNT_W'(1) << (BASE_EXP + int'(sel_i))) - CNT_W'(1);
  assign step     = en_i & ~restart_i & tick_i & (cnt_q == last_cnt);
  assign s1_exp_o = step & (st_q == WS_ARM);
  assign s2_exp_o = step & (st_q == WS_LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr_i || !en_i) begin
      st_d  = WS_IDLE;
      cnt_d = '0;
    end else if (restart_i || st_q == WS_IDLE) begin
      st_d  = WS_ARM;
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == last_cnt) begin
        st_d  = (st_q == WS_ARM) ? WS_LAST : WS_ARM;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen
  import wdog_rst_pkg::*;
#(
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_i,
  input  logic            rtm_i,
  input  logic            wd_exp_i,
  input  logic            s1_exp_i,
  input  logic [NSRC-1:0] attr_i,
  input  logic            nmi_en_i,
  input  logic            init_en_i,
  input  logic            restart_i,
  input  logic            wd_en_i,
  output logic            hard_req_o,
  output logic            evt_we_o,
  output logic [NSRC-1:0] evt_code_o,
  output logic            sys_rst_o,
  output logic            init_o,
  output logic            nmi_o
);
  localparam int HC_W = $clog2(HARD_CYC + 1);
  localparam int SC_W = $clog2(SOFT_CYC + 1);

  logic            fp_q, rtm_q;
  logic [NSRC-1:0] req, pick;
  logic            found, soft_sel, any_req, init_load;
  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic [SC_W-1:0] scnt_q, scnt_d;
  logic            nmi_q, nmi_d;

  always_comb begin
    req          = '0;
    req[SRC_FP]  = fp_i & ~fp_q;
    req[SRC_RTM] = rtm_i & ~rtm_q;
    req[SRC_WD]  = wd_exp_i;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign any_req    = |req;
  assign soft_sel   = |(pick & attr_i);
  assign hard_req_o = any_req & ~soft_sel;
  assign evt_we_o   = any_req;
  assign evt_code_o = pick;
  assign init_load  = (any_req & soft_sel) | (s1_exp_i & init_en_i);

  always_comb begin
    hcnt_d = hcnt_q;
    scnt_d = scnt_q;
    nmi_d  = nmi_q;
    if (hard_req_o) hcnt_d = HC_W'(HARD_CYC);
    else if (hcnt_q != '0) hcnt_d = hcnt_q - HC_W'(1);
    if (init_load) scnt_d = SC_W'(SOFT_CYC);
    else if (scnt_q != '0) scnt_d = scnt_q - SC_W'(1);
    if (hard_req_o || restart_i || !wd_en_i) nmi_d = 1'b0;
    else if (s1_exp_i && nmi_en_i) nmi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q   <= 1'b0;
      rtm_q  <= 1'b0;
      hcnt_q <= '0;
      scnt_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      fp_q   <= fp_i;
      rtm_q  <= rtm_i;
      hcnt_q <= hcnt_d;
      scnt_q <= scnt_d;
      nmi_q  <= nmi_d;
    end
  end

  assign sys_rst_o = (hcnt_q != '0);
  assign init_o    = (scnt_q != '0);
  assign nmi_o     = nmi_q;
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl
  import wdog_rst_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 4,
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr_i,
  input  logic       bus_dsel_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       tick_i,
  input  logic       fp_rst_i,
  input  logic       rtm_rst_i,
  input  logic       swap_sw_i,
  input  logic       latch_open_i,
  output logic       sys_rst_o,
  output logic       init_o,
  output logic       nmi_o,
  output logic       swap_irq_o,
  output logic       latch_irq_o
);
  logic             hard_req, evt_we, restart, wd_en, s1_exp, s2_exp;
  logic [NSRC-1:0]  evt_code, attr, evt;
  logic [SEL_W-1:0] wd_sel;
  logic [3:0]       ien;

  wdog_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_i(bus_wr_i), .bus_dsel_i(bus_dsel_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .hard_clr_i(hard_req), .evt_we_i(evt_we), .evt_code_i(evt_code),
    .wd_en_o(wd_en), .wd_sel_o(wd_sel), .ien_o(ien),
    .attr_o(attr), .evt_o(evt), .restart_o(restart)
  );

  wdog_timer #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .en_i(wd_en), .sel_i(wd_sel), .tick_i(tick_i),
    .restart_i(restart), .clr_i(hard_req),
    .s1_exp_o(s1_exp), .s2_exp_o(s2_exp)
  );

  wdog_rstgen #(.HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC)) u_rstgen (
    .clk(clk), .rst_n(rst_n),
    .fp_i(fp_rst_i), .rtm_i(rtm_rst_i),
    .wd_exp_i(s2_exp), .s1_exp_i(s1_exp), .attr_i(attr),
    .nmi_en_i(ien[0]), .init_en_i(ien[1]),
    .restart_i(restart), .wd_en_i(wd_en),
    .hard_req_o(hard_req), .evt_we_o(evt_we), .evt_code_o(evt_code),
    .sys_rst_o(sys_rst_o), .init_o(init_o), .nmi_o(nmi_o)
  );

  assign swap_irq_o  = swap_sw_i & ien[2];
  assign latch_irq_o = latch_open_i & ien[3];
endmodule

// File: rtl/wdog_rst_chk.sv
module wdog_rst_chk #(
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       init,
  input logic       nmi,
  input logic       nmi_en,
  input logic       wd_en,
  input logic [3:0] ien,
  input logic [2:0] evt,
  input logic       swap_irq,
  input logic       swap_sw
);
  int hrun_q, srun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrun_q <= 0;
      srun_q <= 0;
    end else begin
      hrun_q <= sys_rst ? hrun_q + 1 : 0;
      srun_q <= init ? srun_q + 1 : 0;
    end
  end

  p_hard_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> hrun_q == HARD_CYC);
  p_hard_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> hrun_q < HARD_CYC);
  p_soft_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init) |-> srun_q == SOFT_CYC);
  p_hard_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> (!wd_en && ien == 4'h0));
  p_event_logged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> evt != 3'b000);
  p_event_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt));
  p_nmi_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> nmi_en);
  p_swap_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    swap_irq |-> swap_sw);
endmodule

bind wdog_rst_ctrl wdog_rst_chk #(.HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst_o), .init(init_o), .nmi(nmi_o),
  .nmi_en(ien[0]), .wd_en(wd_en), .ien(ien), .evt(evt),
  .swap_irq(swap_irq_o), .swap_sw(swap_sw_i)
);

// File: tb/wdog_rst_ctrl_bench.sv
`timescale 1ns/1ps
module wdog_rst_ctrl_bench;
  localparam int S_RD = 0, S_SYS = 1, S_INIT = 2, S_NMI = 3, S_SWAP = 4, S_LATCH = 5, S_VAL = 6;

  typedef struct {
    string req;
    int    sig;
    int    exp;
    int    act;
  } chk_t;

  logic       clk, rst_n;
  logic       bus_wr, bus_dsel, tick, fp, rtm, swap, latch;
  logic [7:0] wdata, rdata;
  logic       sys_rst, init, nmi, swap_irq, latch_irq;

  chk_t q[$];
  int   nchk, nerr;
  bit   done;

  wdog_rst_ctrl u_wdog_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_dsel_i(bus_dsel),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick),
    .fp_rst_i(fp), .rtm_rst_i(rtm), .swap_sw_i(swap), .latch_open_i(latch),
    .sys_rst_o(sys_rst), .init_o(init), .nmi_o(nmi),
    .swap_irq_o(swap_irq), .latch_irq_o(latch_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // scoreboard monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        chk_t c;
        int   a;
        c = q.pop_front();
        case (c.sig)
          S_RD:    a = int'(rdata);
          S_SYS:   a = int'(sys_rst);
          S_INIT:  a = int'(init);
          S_NMI:   a = int'(nmi);
          S_SWAP:  a = int'(swap_irq);
          S_LATCH: a = int'(latch_irq);
          default: a = c.act;
        endcase
        nchk++;
        if (a != c.exp) begin
          nerr++;
          $display("FAIL %s: sig %0d actual=%0h expected=%0h", c.req, c.sig, a, c.exp);
        end
      end
    end
  end

  task automatic push(input string req, input int sig, input int exp, input int act = 0);
    chk_t c;
    c.req = req; c.sig = sig; c.exp = exp; c.act = act;
    q.push_back(c);
  endtask

  task automatic bus(input logic dsel, input logic [7:0] v);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_dsel = dsel; wdata = v;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
    bus(1'b0, idx);
    bus(1'b1, v);
  endtask

  task automatic rd_chk(input logic [7:0] idx, input int exp, input string req);
    bus(1'b0, idx);
    push(req, S_RD, exp);
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic high_len(input int sig, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if ((sig == S_SYS ? sys_rst : init) == 1'b1) n++;
      else break;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    int len;
    nchk = 0; nerr = 0; done = 0;
    rst_n = 1'b0; bus_wr = 0; bus_dsel = 0; wdata = 0; tick = 0;
    fp = 0; rtm = 0; swap = 0; latch = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R2 reset state
    push("R2 sys_rst", S_SYS, 0); push("R2 init", S_INIT, 0); push("R2 nmi", S_NMI, 0);
    idle(1);
    rd_chk(8'h01, 0, "R2 ctrl");
    rd_chk(8'h03, 0, "R2 ien");
    rd_chk(8'h04, 0, "R2 event");
    rd_chk(8'h05, 0, "R2 attr");

    // R1 register port
    reg_wr(8'h03, 8'hFF); push("R1 ien readback", S_RD, 8'h0F); idle(1);
    reg_wr(8'h01, 8'hFF); push("R1 ctrl readback", S_RD, 8'h17); idle(1);
    reg_wr(8'h01, 8'h00);
    reg_wr(8'h0A, 8'h55); push("R1 unused index", S_RD, 0); idle(1);
    rd_chk(8'h02, 0, "R1 kick reads 0");

    // R11 interrupt gating
    reg_wr(8'h03, 8'h00);
    swap = 1; latch = 1; idle(1);
    push("R11 swap masked", S_SWAP, 0); push("R11 latch masked", S_LATCH, 0); idle(1);
    reg_wr(8'h03, 8'h0C);
    push("R11 swap on", S_SWAP, 1); push("R11 latch on", S_LATCH, 1); idle(1);
    swap = 0; idle(1);
    push("R11 swap follows", S_SWAP, 0); idle(1);
    latch = 0;

    // R3 first stage, sel 0 -> 16 ticks, NMI+INIT enabled
    reg_wr(8'h03, 8'h03);
    reg_wr(8'h01, 8'h10);
    idle(2);
    ticks(15);
    push("R3 no nmi early", S_NMI, 0); push("R3 no init early", S_INIT, 0);
    ticks(1);
    push("R3 nmi at expiry", S_NMI, 1);
    high_len(S_INIT, len);
    push("R3 init pulse length", S_VAL, 4, len);
    // R5 kick after first expiry cancels hard reset
    reg_wr(8'h02, 8'h00);
    push("R5 kick clears nmi", S_NMI, 0); idle(1);
    ticks(16);
    push("R5 first stage again", S_NMI, 1); push("R5 no hard reset", S_SYS, 0);
    idle(6);
    // R4 second stage -> hard reset
    ticks(15);
    push("R4 not yet", S_SYS, 0);
    ticks(1);
    push("R4 hard reset asserted", S_SYS, 1);
    high_len(S_SYS, len);
    push("R6 hard length", S_VAL, 16, len);
    push("R6 nmi cleared", S_NMI, 0); idle(1);
    rd_chk(8'h01, 0, "R6 ctrl default");
    rd_chk(8'h03, 0, "R6 ien default");
    rd_chk(8'h04, 8'h04, "R9 watchdog event kept");

    // R8 watchdog soft attribute
    reg_wr(8'h05, 8'h04);
    reg_wr(8'h01, 8'h10);
    idle(2);
    ticks(32);
    push("R8 wd soft init", S_INIT, 1); push("R8 wd soft no sysrst", S_SYS, 0);
    high_len(S_INIT, len);
    push("R7 soft length", S_VAL, 4, len);
    rd_chk(8'h01, 8'h10, "R7 ctrl kept");
    rd_chk(8'h05, 8'h04, "R7 attr kept");
    reg_wr(8'h04, 8'h7F); push("R9 non-clear write ignored", S_RD, 8'h04); idle(1);
    reg_wr(8'h04, 8'hFF); push("R9 clear", S_RD, 0); idle(1);

    // R5 disable stops the timer
    reg_wr(8'h03, 8'h01);
    reg_wr(8'h01, 8'h10);
    idle(2);
    ticks(10);
    reg_wr(8'h01, 8'h00);
    ticks(40);
    push("R5 disabled no nmi", S_NMI, 0); push("R5 disabled no init", S_INIT, 0);
    push("R5 disabled no reset", S_SYS, 0); idle(1);

    // R10 front panel hard, edge only
    reg_wr(8'h05, 8'h00);
    @(posedge clk); #1 fp = 1;
    @(posedge clk); #1;
    push("R8 fp hard", S_SYS, 1);
    high_len(S_SYS, len);
    push("R6 fp hard length", S_VAL, 16, len);
    idle(5);
    push("R10 level does not retrigger", S_SYS, 0); idle(1);
    fp = 0;
    rd_chk(8'h04, 8'h01, "R9 fp event");

    // R8 front panel soft, config kept
    reg_wr(8'h05, 8'h01);
    reg_wr(8'h01, 8'h13);
    @(posedge clk); #1 fp = 1;
    @(posedge clk); #1;
    push("R8 fp soft init", S_INIT, 1); push("R8 fp soft no sysrst", S_SYS, 0);
    high_len(S_INIT, len);
    push("R7 fp soft length", S_VAL, 4, len);
    fp = 0;
    rd_chk(8'h01, 8'h13, "R7 ctrl kept after fp soft");
    reg_wr(8'h01, 8'h00);

    // R8 rear hard
    @(posedge clk); #1 rtm = 1;
    @(posedge clk); #1;
    push("R8 rtm hard", S_SYS, 1);
    high_len(S_SYS, len);
    rtm = 0;
    rd_chk(8'h04, 8'h02, "R9 rtm event");

    // R10 coincident: fp soft beats rtm hard
    reg_wr(8'h05, 8'h01);
    @(posedge clk); #1 fp = 1; rtm = 1;
    @(posedge clk); #1;
    push("R10 priority soft", S_INIT, 1); push("R10 priority no sysrst", S_SYS, 0);
    idle(6);
    fp = 0; rtm = 0;
    rd_chk(8'h04, 8'h01, "R10 fp wins event");

    // R3 select 1 -> 32 ticks
    reg_wr(8'h05, 8'h00);
    reg_wr(8'h03, 8'h01);
    reg_wr(8'h01, 8'h11);
    idle(2);
    ticks(31);
    push("R3 sel1 not yet", S_NMI, 0);
    ticks(1);
    push("R3 sel1 expiry", S_NMI, 1); idle(1);
    reg_wr(8'h01, 8'h00);
    push("R5 ctrl write clears nmi", S_NMI, 0);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: bench hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule